// File: doc/BRIEF.md
# Dual-Clock FIFO with Selectable Read Timing

This block is a 36-bit first-in first-out buffer whose write port and read port each run on a free-running clock of their own. The two clocks may be unrelated, or both may be tied to the same net. The pointers cross between the domains as Gray code through two-flop synchronizers. As a result, every flag asserts at once in the domain that owns it and releases a few cycles late, which errs on the safe side.

A static mode input picks the read discipline.

- **Standard mode:** the read-side flag means "empty" and the write-side flag means "full". A word leaves the buffer only on a read enable, and it appears on the data output after that read-clock edge.
- **Fall-through mode:** the flags mean "output ready" and "input ready". The oldest word is moved into the output register with no request. A read enable takes that word and advances to the next one.

Two threshold values for almost-empty and almost-full are captured while reset is held. Each almost flag is produced in the clock domain that observes it.

Top module: `dcfifo_modesel`

## Requirements
- R1: While reset is low and after it is released, both pointers are zero. In standard mode `empty_or`=1 and `full_ir`=0. In fall-through mode `empty_or` (output ready)=0 and `full_ir` (input ready)=1. `almost_empty`=1, and `almost_full`=0 as long as the full offset is below DEPTH.
- R2: In standard mode, `rd_en` high at a read edge while `empty_or`=0 loads the oldest word onto `rd_data` at that edge. Words come out in write order, and `empty_or` rises at the edge that removes the last word.
- R3: With a shared clock, a write into an empty buffer clears `empty_or` (standard mode) at the second clock edge after the write edge.
- R4: In fall-through mode with a shared clock, `empty_or` rises and the written word appears on `rd_data` at the third edge after the write edge, with no read request. The word holds while `rd_en` is low. A read edge advances to the next word, and `empty_or` falls when no further word is stored.
- R5: After DEPTH writes with no reads, the full condition shows right after the last write edge (`full_ir`=1 in standard mode). A write while full is discarded, and the buffer later yields exactly DEPTH words.
- R6: In standard mode, a read while `empty_or`=1 is ignored. `rd_data` and the read pointer are unchanged, and the next word written is the next word read.
- R7: `almost_empty` is 1 when the read-side word count (including the output register in fall-through mode) is less than or equal to the empty offset, and 0 otherwise.
- R8: `almost_full` is 1 when free space (DEPTH minus the write-side word count) is less than or equal to the full offset, and 0 otherwise.
- R9: With a shared clock, a write and a read on the same edge are both accepted. The stream of words keeps its order, with no loss and no duplicate.
- R10: With unrelated clocks, every word written is read once and in order. Each synchronized pointer changes by at most one bit per edge of its source clock.
- R11: The offsets are taken from `ae_offset` and `af_offset` only while reset is low. Changing these inputs afterwards has no effect on the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous active-low reset for both sides; offsets are captured while low |
| fwft_mode | input | 1 | 0 = standard timing, 1 = fall-through timing; static |
| ae_offset | input | $clog2(DEPTH) | Almost-empty threshold, captured during reset |
| af_offset | input | $clog2(DEPTH) | Almost-full threshold, captured during reset |
| wr_en | input | 1 | Write request |
| wr_data | input | WIDTH | Write data |
| full_ir | output | 1 | Full (standard mode) or input ready (fall-through mode) |
| almost_full | output | 1 | Free space at or below the full offset |
| rd_en | input | 1 | Read request |
| rd_data | output | WIDTH | Read data / head word |
| empty_or | output | 1 | Empty (standard mode) or output ready (fall-through mode) |
| almost_empty | output | 1 | Word count at or below the empty offset |

## Verification
The bench checks the exact edge at which the empty flag and the fall-through ready flag release after a write. A design with a missing or extra synchronizer stage would release one cycle early or late, and a fall-through design without prefetch would never raise ready. It writes past full and reads past empty, then drains and refills the buffer. A design that moved a pointer on a refused request would return one word too many, or one stale word. It streams same-edge writes and reads, where a design that dropped one of the two requests would corrupt the sequence. It also changes the offset inputs after reset, which would catch a design that reads the thresholds live instead of capturing them.

// File: rtl/dcfifo_modesel.sv
module dcfifo_modesel #(
  parameter int WIDTH = 36,
  parameter int DEPTH = 2048,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             wr_clk,
  input  logic             rd_clk,
  input  logic             rst_n,
  input  logic             fwft_mode,
  input  logic [AW-1:0]    ae_offset,
  input  logic [AW-1:0]    af_offset,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  output logic             full_ir,
  output logic             almost_full,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  output logic             empty_or,
  output logic             almost_empty
);

  function automatic logic [AW:0] to_gray(input logic [AW:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [AW:0] from_gray(input logic [AW:0] g);
    logic [AW:0] b;
    b[AW] = g[AW];
    for (int i = AW - 1; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  localparam logic [AW:0] CAP = (AW+1)'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW:0] wptr, wgray, rg_s1, rg_s2;
  logic [AW:0] rptr, rgray, wg_s1, wg_s2;
  logic [AW-1:0] ae_q, af_q;
  logic ov;

  // write domain
  logic [AW:0] wfill, wfree;
  logic full_int, do_wr;
  assign wfill    = wptr - from_gray(rg_s2);
  assign wfree    = CAP - wfill;
  assign full_int = (wfill == CAP);
  assign do_wr    = wr_en && !full_int;

  always_ff @(posedge wr_clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      wgray <= '0;
      rg_s1 <= '0;
      rg_s2 <= '0;
      af_q  <= af_offset;
    end else begin
      rg_s1 <= rgray;
      rg_s2 <= rg_s1;
      if (do_wr) begin
        wptr  <= wptr + 1'b1;
        wgray <= to_gray(wptr + 1'b1);
      end
    end
  end

  always_ff @(posedge wr_clk)
    if (do_wr) mem[wptr[AW-1:0]] <= wr_data;

  // read domain
  logic [AW:0] rfill, rcount;
  logic ram_empty, load;
  assign rfill     = from_gray(wg_s2) - rptr;
  assign ram_empty = (rfill == '0);
  assign rcount    = rfill + {{AW{1'b0}}, fwft_mode & ov};
  assign load      = !ram_empty && (fwft_mode ? (!ov || rd_en) : rd_en);

  always_ff @(posedge rd_clk or negedge rst_n) begin
    if (!rst_n) begin
      rptr    <= '0;
      rgray   <= '0;
      wg_s1   <= '0;
      wg_s2   <= '0;
      ov      <= 1'b0;
      rd_data <= '0;
      ae_q    <= ae_offset;
    end else begin
      wg_s1 <= wgray;
      wg_s2 <= wg_s1;
      if (load) begin
        rptr    <= rptr + 1'b1;
        rgray   <= to_gray(rptr + 1'b1);
        rd_data <= mem[rptr[AW-1:0]];
      end
      if (!fwft_mode)  ov <= 1'b0;
      else if (load)   ov <= 1'b1;
      else if (rd_en)  ov <= 1'b0;
    end
  end

  assign full_ir      = fwft_mode ? !full_int : full_int;
  assign almost_full  = wfree <= {1'b0, af_q};
  assign empty_or     = fwft_mode ? ov : ram_empty;
  assign almost_empty = rcount <= {1'b0, ae_q};

endmodule

module dcfifo_modesel_chk #(
  parameter int WIDTH = 36,
  parameter int DEPTH = 2048,
  parameter int AW = 11
) (
  input logic             wr_clk,
  input logic             rd_clk,
  input logic             rst_n,
  input logic             fwft_mode,
  input logic             wr_en,
  input logic             rd_en,
  input logic             full_int,
  input logic             ram_empty,
  input logic             ov,
  input logic [AW:0]      wptr,
  input logic [AW:0]      rptr,
  input logic [AW:0]      wgray,
  input logic [AW:0]      rgray,
  input logic [AW:0]      wfill,
  input logic [WIDTH-1:0] rd_data
);

  // R5
  no_overflow_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
    (wr_en && full_int) |=> $stable(wptr));

  // R5
  fill_bound_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
    wfill <= (AW+1)'(DEPTH));

  // R6
  no_underflow_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
    (rd_en && !fwft_mode && ram_empty) |=> ($stable(rptr) && $stable(rd_data)));

  // R4
  head_hold_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
    (fwft_mode && ov && !rd_en) |=> (ov && $stable(rd_data)));

  // R10
  wgray_step_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
    $countones(wgray ^ $past(wgray)) <= 1);

  // R10
  rgray_step_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
    $countones(rgray ^ $past(rgray)) <= 1);

endmodule

bind dcfifo_modesel dcfifo_modesel_chk #(.WIDTH(WIDTH), .DEPTH(DEPTH), .AW(AW)) chk_i (
  .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .fwft_mode(fwft_mode),
  .wr_en(wr_en), .rd_en(rd_en), .full_int(full_int), .ram_empty(ram_empty),
  .ov(ov), .wptr(wptr), .rptr(rptr), .wgray(wgray), .rgray(rgray),
  .wfill(wfill), .rd_data(rd_data)
);

// File: tb/dcfifo_modesel_tb.sv
module dcfifo_modesel_tb_top;
  localparam int W = 36;
  localparam int D = 16;
  localparam int A = 4;

  logic clk = 0, aclk = 0, async_sel = 0;
  logic rst_n = 0, fwft = 0;
  logic [A-1:0] ae_off = 2, af_off = 3;
  logic wr_en = 0, rd_en = 0;
  logic [W-1:0] wr_data = '0;
  logic full_ir, almost_full, empty_or, almost_empty;
  logic [W-1:0] rd_data;
  logic rd_clk;

  always #4 clk = ~clk;
  always #7 aclk = ~aclk;
  assign rd_clk = async_sel ? aclk : clk;

  dcfifo_modesel #(.WIDTH(W), .DEPTH(D)) dut_i (
    .wr_clk(clk), .rd_clk(rd_clk), .rst_n(rst_n), .fwft_mode(fwft),
    .ae_offset(ae_off), .af_offset(af_off), .wr_en(wr_en), .wr_data(wr_data),
    .full_ir(full_ir), .almost_full(almost_full), .rd_en(rd_en),
    .rd_data(rd_data), .empty_or(empty_or), .almost_empty(almost_empty));

  int n_chk = 0, n_fail = 0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h @%0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset(input logic mode);
    rst_n = 0; fwft = mode; wr_en = 0; rd_en = 0;
    ae_off = 2; af_off = 3;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic push(input logic [W-1:0] d);
    @(negedge clk); wr_en = 1; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic pop(output logic [W-1:0] d);
    @(negedge rd_clk); rd_en = 1;
    @(negedge rd_clk); rd_en = 0; d = rd_data;
  endtask

  task automatic t_reset_std;
    do_reset(0);
    chk("R1 empty", empty_or, 1);
    chk("R1 full", full_ir, 0);
    chk("R1 almost_empty", almost_empty, 1);
    chk("R1 almost_full", almost_full, 0);
  endtask

  task automatic t_std_basic;
    logic [W-1:0] d;
    push(36'hA1);
    chk("R3 empty edge0", empty_or, 1);
    @(negedge clk); chk("R3 empty edge1", empty_or, 1);
    @(negedge clk); chk("R3 empty edge2", empty_or, 0);
    push(36'hA2); push(36'hA3);
    repeat (3) @(negedge clk);
    pop(d); chk("R2 word0", d, 36'hA1);
    pop(d); chk("R2 word1", d, 36'hA2);
    pop(d); chk("R2 word2", d, 36'hA3);
    chk("R2 empty after drain", empty_or, 1);
  endtask

  task automatic t_underflow;
    logic [W-1:0] d;
    @(negedge clk); rd_en = 1;
    repeat (3) @(negedge clk);
    rd_en = 0;
    chk("R6 data held", rd_data, 36'hA3);
    chk("R6 still empty", empty_or, 1);
    push(36'hD4);
    repeat (3) @(negedge clk);
    pop(d); chk("R6 next word", d, 36'hD4);
  endtask

  task automatic t_levels;
    logic [W-1:0] d;
    do_reset(0);
    push(100); push(101);
    repeat (3) @(negedge clk);
    chk("R7 two words", almost_empty, 1);
    push(102);
    repeat (3) @(negedge clk);
    chk("R7 three words", almost_empty, 0);
    for (int i = 3; i < 12; i++) push(W'(100 + i));
    chk("R8 free4", almost_full, 0);
    push(112);
    chk("R8 free3", almost_full, 1);
    ae_off = 15; af_off = 0;
    repeat (3) @(negedge clk);
    chk("R11 ae unchanged", almost_empty, 0);
    chk("R11 af unchanged", almost_full, 1);
    for (int i = 13; i < 16; i++) push(W'(100 + i));
    chk("R5 full", full_ir, 1);
    push(36'hBAD);
    chk("R5 still full", full_ir, 1);
    for (int i = 0; i < 16; i++) begin
      pop(d); chk("R5 drain", d, 64'(100 + i));
    end
    chk("R5 no extra word", empty_or, 1);
  endtask

  task automatic t_simul;
    logic [W-1:0] d;
    do_reset(0);
    for (int i = 0; i < 4; i++) push(W'(200 + i));
    repeat (3) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (i > 0) chk("R9 stream", rd_data, 64'(200 + i - 1));
      wr_en = 1; wr_data = W'(204 + i); rd_en = 1;
    end
    @(negedge clk);
    chk("R9 stream last", rd_data, 207);
    wr_en = 0; rd_en = 0;
    repeat (3) @(negedge clk);
    for (int i = 8; i < 12; i++) begin
      pop(d); chk("R9 tail", d, 64'(200 + i));
    end
    chk("R9 empty", empty_or, 1);
  endtask

  task automatic t_fwft;
    do_reset(1);
    chk("R1 ready low", empty_or, 0);
    chk("R1 input ready", full_ir, 1);
    push(36'hF1);
    chk("R4 edge0", empty_or, 0);
    @(negedge clk); chk("R4 edge1", empty_or, 0);
    @(negedge clk); chk("R4 edge2", empty_or, 0);
    @(negedge clk); chk("R4 edge3", empty_or, 1);
    chk("R4 head word", rd_data, 36'hF1);
    push(36'hF2);
    repeat (3) @(negedge clk);
    chk("R4 head held", rd_data, 36'hF1);
    chk("R7 count2 fwft", almost_empty, 1);
    @(negedge clk); rd_en = 1;
    @(negedge clk); rd_en = 0;
    chk("R4 advance", rd_data, 36'hF2);
    chk("R4 ready kept", empty_or, 1);
    @(negedge clk); rd_en = 1;
    @(negedge clk); rd_en = 0;
    chk("R4 ready falls", empty_or, 0);
  endtask

  task automatic t_async;
    logic [W-1:0] d;
    async_sel = 1;
    do_reset(0);
    for (int i = 0; i < 5; i++) push(W'(300 + i));
    for (int i = 0; i < 5; i++) begin
      for (int k = 0; k < 20 && empty_or; k++) @(negedge rd_clk);
      pop(d); chk("R10 async order", d, 64'(300 + i));
    end
    repeat (4) @(negedge rd_clk);
    chk("R10 async empty", empty_or, 1);
  endtask

  initial begin
    t_reset_std();
    t_std_basic();
    t_underflow();
    t_levels();
    t_simul();
    t_fwft();
    t_async();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule